// File: doc/BRIEF.md
# Memory lock-bit protection logic

This block keeps a two-bit memory lock field and uses it to gate the commands that a programming interface sends. Commands for flash/EEPROM writes, flash/EEPROM readback and fuse writes come from either the serial or the parallel programming path. For each one, the block decides whether it is allowed or refused. Both paths follow the same rules, so the block does not need to know which path a command came from. The lock bits are active low, where 1 means unprogrammed. A write to the lock field can only move it toward stronger protection. The only way back to the open state is a chip erase, which also invalidates the stored memory contents.

Each command arrives as a one-cycle strobe carrying an opcode and a data byte. One clock later the block raises either a one-cycle grant or a one-cycle deny. A granted memory read returns the byte from the array. A refused read returns all ones. Three level outputs show which classes of operation are currently permitted. The full lock byte can always be read back.

Top module: `lock_guard`

## Requirements
- R1: While `por_n` is low and after it is released, `lock_byte` is 0xFF, `mem_valid` is 0, `grant` and `deny` are 0, `rd_data` is 0xFF, and `prog_ok`, `verify_ok` and `fuse_ok` are 1.
- R2: `lock_byte[7:2]` always reads as all ones. `lock_byte[1]` is LB2 and `lock_byte[0]` is LB1.
- R3: A lock write (opcode 1) is always granted. It replaces the lock bits with the old bits ANDed with `cmd_data[1:0]`, so a write can clear bits but an attempt to set a bit is ignored.
- R4: A chip erase (opcode 2) is always granted. In the same cycle it returns `lock_byte` to 0xFF and clears `mem_valid`.
- R5: With LB2=1 and LB1=1, memory program (opcode 3), memory read (opcode 4) and fuse program (opcode 5) are all granted. A granted memory program sets `mem_valid`. A granted read places `array_rdata` on `rd_data`.
- R6: With LB2=1 and LB1=0, memory program and fuse program are denied, and memory read is still granted.
- R7: With LB2=0, memory program, memory read and fuse program are all denied, whatever the value of LB1.
- R8: The cycle after a command is accepted, exactly one of `grant` and `deny` is high, for one cycle only. A denied command leaves the lock bits and `mem_valid` unchanged. A denied read sets `rd_data` to 0xFF.
- R9: `prog_ok` and `fuse_ok` are 1 only when both lock bits are 1. `verify_ok` is 1 exactly when LB2 is 1.
- R10: Opcodes 0, 6 and 7 are undefined and are denied without any change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on initialisation of the stored state |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 8 | Command data byte |
| array_rdata | input | 8 | Byte read from the memory array |
| grant | output | 1 | One-cycle pulse: the previous command was carried out |
| deny | output | 1 | One-cycle pulse: the previous command was refused |
| rd_data | output | 8 | Result of the last memory read |
| lock_byte | output | 8 | Current lock byte readback |
| mem_valid | output | 1 | Memory has been programmed since the last erase |
| prog_ok | output | 1 | Memory programming currently permitted |
| verify_ok | output | 1 | Memory readback currently permitted |
| fuse_ok | output | 1 | Fuse programming currently permitted |

## Verification
The hardest state to reach is the one where LB2 is programmed but LB1 is not. No sequence that programs LB1 first can lead there, because bits can only be cleared. The stimulus first erases the part and then writes a data byte that clears only bit 1. The bench then confirms that this state refuses reads as strictly as the fully locked state does. The other awkward case is an attempt to set a bit back to 1. The bench writes all ones over a partly locked field and reads the lock byte back to confirm that nothing moved.

// File: rtl/lock_guard.sv
module lock_guard #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [7:0]    cmd_data,
  input  logic [DW-1:0] array_rdata,
  output logic          grant,
  output logic          deny,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    lock_byte,
  output logic          mem_valid,
  output logic          prog_ok,
  output logic          verify_ok,
  output logic          fuse_ok
);

  localparam logic [2:0] OP_LOCK_WR = 3'd1;
  localparam logic [2:0] OP_ERASE   = 3'd2;
  localparam logic [2:0] OP_MEM_WR  = 3'd3;
  localparam logic [2:0] OP_MEM_RD  = 3'd4;
  localparam logic [2:0] OP_FUSE_WR = 3'd5;

  logic [1:0] lb_q;
  logic       allow;

  assign lock_byte = {6'h3F, lb_q};
  assign prog_ok   = &lb_q;
  assign fuse_ok   = &lb_q;
  assign verify_ok = lb_q[1];

  always_comb begin
    case (cmd_op)
      OP_LOCK_WR, OP_ERASE: allow = 1'b1;
      OP_MEM_WR:            allow = prog_ok;
      OP_MEM_RD:            allow = verify_ok;
      OP_FUSE_WR:           allow = fuse_ok;
      default:              allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lb_q      <= 2'b11;
      mem_valid <= 1'b0;
      grant     <= 1'b0;
      deny      <= 1'b0;
      rd_data   <= '1;
    end else begin
      grant <= cmd_valid && allow;
      deny  <= cmd_valid && !allow;
      if (cmd_valid && allow) begin
        case (cmd_op)
          OP_LOCK_WR: lb_q <= lb_q & cmd_data[1:0];
          OP_ERASE: begin
            lb_q      <= 2'b11;
            mem_valid <= 1'b0;
          end
          OP_MEM_WR: mem_valid <= 1'b1;
          OP_MEM_RD: rd_data   <= array_rdata;
          default: ;
        endcase
      end else if (cmd_valid && cmd_op == OP_MEM_RD) begin
        rd_data <= '1;
      end
    end
  end

  // R3
  lock_only_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(cmd_valid && cmd_op == OP_ERASE) |=> (lb_q & ~$past(lb_q)) == 2'b00);

  // R4
  erase_restores_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && cmd_op == OP_ERASE) |=> (lock_byte == 8'hFF && !mem_valid));

  // R8
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({grant, deny}));

  // R8
  deny_keeps_state_chk: assert property (@(posedge clk) disable iff (!por_n)
    deny |-> ($stable(lb_q) && $stable(mem_valid)));

  // R7
  lb2_blocks_read_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && cmd_op == OP_MEM_RD && !lb_q[1]) |=> (deny && rd_data == '1));

  // R6
  lb1_blocks_prog_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && (cmd_op == OP_MEM_WR || cmd_op == OP_FUSE_WR) && !lb_q[0]) |=> deny);

endmodule

// File: tb/lock_guard_test.sv
module lock_guard_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic [7:0] array_rdata = 8'h00;
  logic       grant, deny, mem_valid, prog_ok, verify_ok, fuse_ok;
  logic [7:0] rd_data, lock_byte;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lock_guard uut (
    .clk(clk), .por_n(por_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .array_rdata(array_rdata), .grant(grant), .deny(deny),
    .rd_data(rd_data), .lock_byte(lock_byte), .mem_valid(mem_valid),
    .prog_ok(prog_ok), .verify_ok(verify_ok), .fuse_ok(fuse_ok)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] data);
    @(negedge clk);
    cmd_op = op; cmd_data = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 lock_byte", lock_byte, 8'hFF);
    check("R1 mem_valid", {7'd0, mem_valid}, 8'd0);
    check("R1 grant/deny", {6'd0, grant, deny}, 8'd0);
    check("R1 rd_data", rd_data, 8'hFF);
    check("R1 R9 flags", {5'd0, prog_ok, verify_ok, fuse_ok}, 8'h07);
  endtask

  task automatic t_open();
    issue(3'd3, 8'h00);
    check("R5 prog grant", {6'd0, grant, deny}, 8'h02);
    check("R5 mem_valid", {7'd0, mem_valid}, 8'd1);
    array_rdata = 8'h5A;
    issue(3'd4, 8'h00);
    check("R5 read grant", {6'd0, grant, deny}, 8'h02);
    check("R5 read data", rd_data, 8'h5A);
    issue(3'd5, 8'h00);
    check("R5 fuse grant", {6'd0, grant, deny}, 8'h02);
    @(negedge clk);
    check("R8 single pulse", {6'd0, grant, deny}, 8'h00);
  endtask

  task automatic t_mode_lb1();
    issue(3'd1, 8'h02);
    check("R3 R2 clear LB1", lock_byte, 8'hFE);
    check("R3 lock grant", {6'd0, grant, deny}, 8'h02);
    check("R9 flags lb1", {5'd0, prog_ok, verify_ok, fuse_ok}, 8'h02);
    issue(3'd3, 8'h00);
    check("R6 prog deny", {6'd0, grant, deny}, 8'h01);
    check("R8 mem_valid kept", {7'd0, mem_valid}, 8'd1);
    issue(3'd5, 8'h00);
    check("R6 fuse deny", {6'd0, grant, deny}, 8'h01);
    @(negedge clk);
    check("R8 deny one cycle", {6'd0, grant, deny}, 8'h00);
    array_rdata = 8'h3C;
    issue(3'd4, 8'h00);
    check("R6 read grant", {6'd0, grant, deny}, 8'h02);
    check("R6 read data", rd_data, 8'h3C);
    issue(3'd1, 8'hFF);
    check("R3 set ignored", lock_byte, 8'hFE);
  endtask

  task automatic t_mode_full();
    issue(3'd1, 8'h00);
    check("R3 clear both", lock_byte, 8'hFC);
    issue(3'd4, 8'h00);
    check("R7 read deny", {6'd0, grant, deny}, 8'h01);
    check("R8 denied read data", rd_data, 8'hFF);
    issue(3'd3, 8'h00);
    check("R7 prog deny", {6'd0, grant, deny}, 8'h01);
    issue(3'd5, 8'h00);
    check("R7 fuse deny", {6'd0, grant, deny}, 8'h01);
    check("R9 flags full", {5'd0, prog_ok, verify_ok, fuse_ok}, 8'h00);
  endtask

  task automatic t_undefined();
    issue(3'd0, 8'h00);
    check("R10 op0 deny", {6'd0, grant, deny}, 8'h01);
    issue(3'd7, 8'h00);
    check("R10 op7 deny", {6'd0, grant, deny}, 8'h01);
    issue(3'd6, 8'h00);
    check("R10 op6 deny", {6'd0, grant, deny}, 8'h01);
    check("R10 lock unchanged", lock_byte, 8'hFC);
    check("R10 mem_valid unchanged", {7'd0, mem_valid}, 8'd1);
  endtask

  task automatic t_erase_and_lb2_only();
    issue(3'd2, 8'h00);
    check("R4 erase grant", {6'd0, grant, deny}, 8'h02);
    check("R4 lock restored", lock_byte, 8'hFF);
    check("R4 mem_valid cleared", {7'd0, mem_valid}, 8'd0);
    issue(3'd1, 8'hFD);
    check("R3 clear LB2 only", lock_byte, 8'hFD);
    check("R9 flags lb2", {5'd0, prog_ok, verify_ok, fuse_ok}, 8'h00);
    array_rdata = 8'h81;
    issue(3'd4, 8'h00);
    check("R7 lb2 read deny", {6'd0, grant, deny}, 8'h01);
    check("R7 lb2 read data", rd_data, 8'hFF);
    issue(3'd3, 8'h00);
    check("R7 lb2 prog deny", {6'd0, grant, deny}, 8'h01);
    check("R8 mem_valid held", {7'd0, mem_valid}, 8'd0);
    issue(3'd2, 8'h00);
    issue(3'd3, 8'h00);
    check("R4 R5 prog after erase", {6'd0, grant, deny}, 8'h02);
    check("R5 mem_valid again", {7'd0, mem_valid}, 8'd1);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open();
    t_mode_lb1();
    t_mode_full();
    t_undefined();
    t_erase_and_lb2_only();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule